// File: doc/BRIEF.md
# Quad DAC Serial Register Controller

This block is the digital control side of a four-channel voltage-output converter. A host sends 16-bit command words over a three-wire serial link made of an active-low select, a serial clock and a data line. The three link pins and the load strobe are synchronised into the system clock domain, and edges are found there. At the end of a frame, when the select rises, the word is decoded. It either writes a 12-bit code into the input register of one channel or changes the shutdown state.

Each channel keeps an input register and a DAC register. A level-sensitive, active-low load strobe copies all four input registers into the DAC registers together, so the analog outputs move at the same moment. An asynchronous active-low reset clears every code and every shutdown flag at once, without waiting for a clock edge.

A host with an 8-bit port can send a command as two bytes, right-justified, inside one select-low period. Any bits that arrive before the last sixteen are dropped. The link and strobe pins are plain control pins. There is no valid/ready handshake and no back-pressure: a command is accepted as soon as it is complete, and the host is never stalled.

Top module: `quad_dac_ctrl`

## Requirements
- R1: Data is sampled only on a rising serial-clock edge while the select is low. Serial-clock edges while the select is high add no bits to a frame.
- R2: A word is 16 bits, sent MSB first. Bit 15 is the global shutdown bit and bit 14 the channel shutdown bit. Bits 13:12 are the channel address (0 = A, 1 = B, 2 = C, 3 = D). Bits 11:0 are the code. On the output buses channel n occupies dac_code[12n+11:12n] and shdn[n].
- R3: When a frame holds more than 16 bits, only the last 16 are decoded.
- R4: When a frame holds fewer than 16 bits, it changes no register and no flag.
- R5: A word with both shutdown bits at 0 writes its code into the input register of the addressed channel and clears that channel's shutdown flag.
- R6: A word with bit 15 at 1 sets all four shutdown flags and leaves every stored code unchanged.
- R7: A word with bit 15 at 0 and bit 14 at 1 sets only the addressed channel's shutdown flag and leaves every stored code unchanged.
- R8: While ld_n is high, the DAC registers hold their values. While ld_n is low, all four DAC registers follow their input registers.
- R9: While rst_n is low, all input registers, DAC registers and shutdown flags are zero, with no clock edge needed. This overrides any load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset to zero code |
| spi_sclk | input | 1 | Serial clock, asynchronous to clk |
| spi_csn | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data, MSB first |
| ld_n | input | 1 | Active-low, level-sensitive load strobe for all channels |
| dac_code | output | 48 | Four 12-bit DAC register values, channel A in the low bits |
| shdn | output | 4 | Per-channel shutdown flags, bit 0 = channel A |

## Verification
The hardest states to reach from the ports are frame-length corner cases: frames longer than sixteen bits, frames shorter than sixteen bits, and serial clocks sent while the select is high. Only these show whether the decoder keeps the final sixteen bits and rejects partial words. The random stimulus therefore mixes frame lengths between 1 and 32 bits and adds stray clock bursts between frames. The load strobe is held high across some writes, so buffered but not yet transferred codes can be observed. Reset is asserted in the middle of a frame, with nonzero codes stored, to show that it acts without a clock.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 12;
  localparam int NCH    = 4;
  localparam int ADDR_W = $clog2(NCH);

  typedef struct packed {
    logic              all_off;
    logic              one_off;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
  } qdac_cmd_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  output logic              cmd_vld,
  output logic [WORD_W-1:0] cmd_word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic             sclk_q, csn_q;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] sh;
  logic             sclk_rise, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign cs_rise   = csn_s & ~csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      csn_q    <= 1'b1;
      cnt      <= '0;
      sh       <= '0;
      cmd_vld  <= 1'b0;
      cmd_word <= '0;
    end else begin
      sclk_q  <= sclk_s;
      csn_q   <= csn_s;
      cmd_vld <= 1'b0;
      if (cs_rise && cnt == FULL) begin
        cmd_vld  <= 1'b1;
        cmd_word <= sh;
      end
      if (csn_s) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        sh <= {sh[WORD_W-2:0], sdi_s};
        if (cnt != FULL) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              off_set,
  input  logic [CODE_W-1:0] code,
  input  logic              load,
  output logic [CODE_W-1:0] in_code,
  output logic [CODE_W-1:0] out_code,
  output logic              off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_code <= '0;
      off     <= 1'b0;
    end else if (wr) begin
      in_code <= code;
      off     <= 1'b0;
    end else if (off_set) begin
      off     <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_code <= '0;
    else if (load) out_code <= in_code;
  end
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_sclk,
  input  logic                  spi_csn,
  input  logic                  spi_sdi,
  input  logic                  ld_n,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic [NCH-1:0]        shdn
);
  logic [3:0] raw, syn;
  logic       sclk_s, csn_s, sdi_s, ld_s;
  logic       cmd_vld;
  logic [WORD_W-1:0] cmd_word;
  qdac_cmd_t  cmd;
  logic [NCH*CODE_W-1:0] in_code;

  assign raw = {ld_n, spi_csn, spi_sclk, spi_sdi};

  qdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw), .dout(syn)
  );

  assign {ld_s, csn_s, sclk_s, sdi_s} = syn;

  qdac_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .cmd_vld(cmd_vld), .cmd_word(cmd_word)
  );

  assign cmd = qdac_cmd_t'(cmd_word);

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic sel, wr, off_set;
      assign sel     = (cmd.addr == ADDR_W'(ch));
      assign wr      = cmd_vld & ~cmd.all_off & ~cmd.one_off & sel;
      assign off_set = cmd_vld & (cmd.all_off | (cmd.one_off & sel));

      qdac_chan u_chan (
        .clk(clk), .rst_n(rst_n), .wr(wr), .off_set(off_set),
        .code(cmd.code), .load(~ld_s),
        .in_code(in_code[ch*CODE_W +: CODE_W]),
        .out_code(dac_code[ch*CODE_W +: CODE_W]),
        .off(shdn[ch])
      );
    end
  endgenerate
endmodule

// File: rtl/quad_dac_ctrl_chk.sv
module quad_dac_ctrl_chk
  import qdac_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ld_s,
  input logic                  cmd_vld,
  input logic [WORD_W-1:0]     cmd_word,
  input logic [NCH*CODE_W-1:0] in_code,
  input logic [NCH*CODE_W-1:0] dac_code,
  input logic [NCH-1:0]        shdn
);
  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_word[15] |=> shdn == {NCH{1'b1}}); // R6

  AST_OFF_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && (cmd_word[15] || cmd_word[14]) |=> $stable(in_code)); // R7

  AST_NO_WORD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> $stable(in_code) && $stable(shdn)); // R4

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_s |=> $stable(dac_code)); // R8

  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_s |=> dac_code == $past(in_code)); // R8

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_a
      AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld && !cmd_word[15] && !cmd_word[14] && cmd_word[13:12] == ADDR_W'(ch)
        |=> in_code[ch*CODE_W +: CODE_W] == $past(cmd_word[11:0]) && !shdn[ch]); // R5
    end
  endgenerate
endmodule

bind quad_dac_ctrl quad_dac_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_s(ld_s), .cmd_vld(cmd_vld), .cmd_word(cmd_word),
  .in_code(in_code), .dac_code(dac_code), .shdn(shdn)
);

// File: tb/test_quad_dac_ctrl.sv
`timescale 1ns/1ps
module test_quad_dac_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, ld_n = 1'b1;
  logic [47:0] dac_code;
  logic [3:0]  shdn;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [11:0] in_m [4];
  logic [11:0] dac_m [4];
  logic [3:0]  sh_m;

  always #4 clk = ~clk;

  quad_dac_ctrl i_quad_dac_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_sdi(sdi),
    .ld_n(ld_n), .dac_code(dac_code), .shdn(shdn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] pack_dac();
    logic [47:0] v;
    for (int c = 0; c < 4; c++) v[c*12 +: 12] = dac_m[c];
    return v;
  endfunction

  function automatic void model_word(input logic [15:0] w);
    int a = int'(w[13:12]);
    if (w[15]) sh_m = 4'hF;
    else if (w[14]) sh_m[a] = 1'b1;
    else begin
      in_m[a] = w[11:0];
      sh_m[a] = 1'b0;
    end
  endfunction

  function automatic void model_load();
    for (int c = 0; c < 4; c++) dac_m[c] = in_m[c];
  endfunction

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stray(input int n);
    for (int i = 0; i < n; i++) begin
      sdi = 1'($urandom); clks(4); sclk = 1'b1; clks(4); sclk = 1'b0;
    end
  endtask

  task automatic spi_send(input logic [31:0] bits, input int n);
    csn = 1'b0; clks(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i]; clks(4); sclk = 1'b1; clks(4); sclk = 1'b0;
    end
    clks(4); csn = 1'b1; clks(12);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin in_m[c] = '0; dac_m[c] = '0; end
    sh_m = '0;
    clks(5);
    check("R9 reset codes", 64'(dac_code), 64'(0));
    check("R9 reset shdn", 64'(shdn), 64'(0));
    rst_n = 1'b1; clks(5);

    // R5/R8: write with strobe high is buffered, then transferred
    spi_send(32'h0000_0123, 16); model_word(16'h0123);
    check("R8 hold while ld_n high", 64'(dac_code), 64'(pack_dac()));
    ld_n = 1'b0; clks(6); model_load();
    check("R5 write ch A", 64'(dac_code), 64'(pack_dac()));
    ld_n = 1'b1; clks(6);

    // R3: two bytes plus a leading junk byte, last 16 used
    spi_send(32'h00A5_2ABC, 24); model_word(16'h2ABC);
    ld_n = 1'b0; clks(6); model_load(); ld_n = 1'b1; clks(6);
    check("R3 last 16 bits ch C", 64'(dac_code), 64'(pack_dac()));

    // R1: stray clocks with select high add no bits
    stray(8);
    spi_send(32'h0000_1777, 16); model_word(16'h1777);
    ld_n = 1'b0; clks(6); model_load(); ld_n = 1'b1; clks(6);
    check("R1 stray clocks ignored ch B", 64'(dac_code), 64'(pack_dac()));

    // R4: short frame ignored
    spi_send(32'h0000_3FFF, 15);
    ld_n = 1'b0; clks(6); ld_n = 1'b1; clks(6);
    check("R4 short frame codes", 64'(dac_code), 64'(pack_dac()));
    check("R4 short frame shdn", 64'(shdn), 64'(sh_m));

    // R7 then R6
    spi_send(32'h0000_5000, 16); model_word(16'h5000);
    check("R7 single shutdown", 64'(shdn), 64'(sh_m));
    spi_send(32'h0000_8FFF, 16); model_word(16'h8FFF);
    ld_n = 1'b0; clks(6); model_load(); ld_n = 1'b1; clks(6);
    check("R6 all shutdown flags", 64'(shdn), 64'(sh_m));
    check("R6 codes unchanged", 64'(dac_code), 64'(pack_dac()));

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [31:0] bits;
      logic [15:0] w;
      int n, k;
      bits = $urandom;
      bits[31] = ($urandom % 6 == 0);
      bits[15] = ($urandom % 6 == 0);
      k = $urandom % 4;
      n = (k == 0) ? 1 + $urandom % 15 : (k == 1) ? 16 : 17 + $urandom % 16;
      w = bits[15:0];
      if ($urandom % 3 == 0) stray(1 + $urandom % 5);
      if ($urandom % 2 == 0) begin
        ld_n = 1'b0; clks(6); model_load();
      end
      spi_send(bits, n);
      if (n >= 16) model_word(w);
      if (!ld_n) model_load();
      check(n < 16 ? "R4 random short shdn" : (w[15] ? "R6 random shdn" :
            (w[14] ? "R7 random shdn" : "R5 random shdn")), 64'(shdn), 64'(sh_m));
      check(ld_n ? "R8 random hold" : (n > 16 ? "R3 random follow" : "R2 random follow"),
            64'(dac_code), 64'(pack_dac()));
      if (ld_n) begin
        ld_n = 1'b0; clks(6); model_load();
        check("R8 random load", 64'(dac_code), 64'(pack_dac()));
      end
      ld_n = 1'b1; clks(6);
    end

    // R9: reset mid-frame with stored codes
    spi_send(32'h0000_3ACE, 16); model_word(16'h3ACE);
    spi_send(32'h0000_4000, 16); model_word(16'h4000);
    ld_n = 1'b0; clks(6); model_load();
    csn = 1'b0; clks(4);
    for (int i = 0; i < 5; i++) begin
      sdi = 1'b1; clks(4); sclk = 1'b1; clks(4); sclk = 1'b0;
    end
    #1 rst_n = 1'b0;
    #1;
    check("R9 async clear codes", 64'(dac_code), 64'(0));
    check("R9 async clear shdn", 64'(shdn), 64'(0));
    for (int c = 0; c < 4; c++) begin in_m[c] = '0; dac_m[c] = '0; end
    sh_m = '0;
    csn = 1'b1; clks(4);
    check("R9 held in reset with ld_n low", 64'(dac_code), 64'(0));
    rst_n = 1'b1; clks(6);
    spi_send(32'h0000_3555, 16); model_word(16'h3555); model_load();
    check("R2 after reset ch D", 64'(dac_code), 64'(pack_dac()));
    ld_n = 1'b1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule